// File: doc/BRIEF.md
# Audio bit and frame clock generator

This block runs directly on the audio master clock and produces the serial bit clock and the left/right frame clock that an audio port needs when it drives the link itself. The caller selects a master-clock-to-sample-rate ratio and one of three ways of deriving the bit clock. In the first, the bit clock is the master clock divided by a power of two. In the second, it is a fixed multiple of the sample rate. In the third, it is the sample rate times the channel count, times the word length, times one or two.

Alongside the two clocks, the block gives a serializer three single-cycle strobes. One marks the cycle in which the bit clock goes low, which is when data is launched. One marks the cycle in which it goes high, which is when data is sampled. One marks the first cycle of each frame. A configuration that cannot produce a whole, even number of bit periods per frame raises an error flag, and every clock and strobe output is then held low. A new configuration replaces the running one only at a frame boundary, so the outputs never show a shortened pulse.

Top module: `aclk_gen`

## Requirements
- R1: After synchronous reset, and in the first cycle after it is released, bclk, lrclk, all three strobes and cfg_err are low.
- R2: cfg_fs_sel picks the master clocks per frame: 0=128, 1=192, 2=256, 3=272, 4=384, 5=512, 6=768, 7=1536. With a valid configuration, frame_stb repeats exactly once every that many cycles.
- R3: With cfg_mode=0 (power-of-two divide), one bit period is 2^cfg_div_log2 master clocks. cfg_div_log2 values 0 to 4 are legal, and any larger value is a configuration error.
- R4: With cfg_mode=1 (rate multiple), a frame holds 32 bit periods, or 64 when cfg_rate_x64=1. One bit period is FS/32 or FS/64 master clocks.
- R5: With cfg_mode=2 (channel and word), a frame holds (cfg_chan_m1+1) × word × (cfg_rcw_x2 ? 2 : 1) bit periods. The word length is 16, 20, 24 or 32 for cfg_word_sel 0, 1, 2 and 3.
- R6: For a bit period of D>1 cycles, bclk is low for the first ceil(D/2) cycles and high for the rest. shift_stb is high in the first low cycle, and sample_stb is high in the first high cycle.
- R7: lrclk is low for the first half of the frame's bit periods and high for the second half. Whenever it changes while cfg_err is low, shift_stb is high in the same cycle.
- R8: cfg_mode=3 is a configuration error. So is any setting where the bit period times the bits per frame differs from FS, or the bits per frame are odd. In that case cfg_err is high and bclk, lrclk and all strobes are low. The next valid setting is picked up within two cycles.
- R9: A change to the configuration inputs during a valid frame does not alter that frame. The new setting starts with the cycle after the frame's last cycle.
- R10: When the bit period is one master clock, bclk follows clk, and shift_stb and sample_stb are both high in every cycle.
- R11: frame_stb is high only in the first cycle of a frame, where shift_stb is high and lrclk is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Audio master clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | Bit clock derivation: 0 divide, 1 rate multiple, 2 channel×word, 3 invalid |
| cfg_fs_sel | input | 3 | Master clocks per frame select |
| cfg_div_log2 | input | 3 | Power-of-two divide exponent (mode 0) |
| cfg_rate_x64 | input | 1 | Rate multiple 64 instead of 32 (mode 1) |
| cfg_chan_m1 | input | 3 | Channel count minus one (mode 2) |
| cfg_word_sel | input | 2 | Word length select (mode 2) |
| cfg_rcw_x2 | input | 1 | Double the channel×word bit count (mode 2) |
| bclk | output | 1 | Bit clock |
| lrclk | output | 1 | Frame (left/right) clock |
| shift_stb | output | 1 | Cycle in which bclk falls |
| sample_stb | output | 1 | Cycle in which bclk rises |
| frame_stb | output | 1 | First cycle of a frame |
| cfg_err | output | 1 | Active configuration is unusable |

## Verification
The hardest situation to reach from the ports is a configuration change that lands at an arbitrary point inside a long frame. A new setting must wait for the frame's last cycle and then start cleanly, and the same must hold when the old or the new setting is invalid. The stimulus holds a valid setting for part of a frame and then switches. It measures the number of cycles to the next frame strobe and the length of the frame that follows. It then steps through many $urandom-chosen settings, invalid ones included, each swapped in mid-frame. An independent cycle model checks every output on both clock phases, so the divide-by-one pass-through is checked while clk is high as well as while it is low.

// File: rtl/aclk_pkg.sv
package aclk_pkg;

  typedef enum logic [1:0] {
    MODE_POW2 = 2'd0,
    MODE_RATE = 2'd1,
    MODE_RCW  = 2'd2,
    MODE_RSVD = 2'd3
  } bmode_e;

  localparam int RATIO_W = 11;

  // master clocks per frame for each select code
  function automatic logic [RATIO_W-1:0] fs_ratio(input logic [2:0] sel);
    logic [RATIO_W-1:0] r;
    case (sel)
      3'd0:    r = 11'd128;
      3'd1:    r = 11'd192;
      3'd2:    r = 11'd256;
      3'd3:    r = 11'd272;
      3'd4:    r = 11'd384;
      3'd5:    r = 11'd512;
      3'd6:    r = 11'd768;
      default: r = 11'd1536;
    endcase
    return r;
  endfunction

  function automatic logic [5:0] word_len(input logic [1:0] sel);
    logic [5:0] w;
    case (sel)
      2'd0:    w = 6'd16;
      2'd1:    w = 6'd20;
      2'd2:    w = 6'd24;
      default: w = 6'd32;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/aclk_cfg_calc.sv
// Registered decode of the configuration inputs into cycles per bit,
// bits per frame and a validity flag.
module aclk_cfg_calc
  import aclk_pkg::*;
#(
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    mode,
  input  logic [2:0]    fs_sel,
  input  logic [2:0]    div_log2,
  input  logic          rate_x64,
  input  logic [2:0]    chan_m1,
  input  logic [1:0]    word_sel,
  input  logic          rcw_x2,
  output logic [CW-1:0] cand_div,
  output logic [CW-1:0] cand_bits,
  output logic          cand_err,
  output logic          cand_vld
);

  localparam int PW = 2 * CW;
  localparam logic [2:0] MAX_LOG2 = 3'd4;

  bmode_e        mode_e;
  logic [CW-1:0] fs;
  logic [CW-1:0] div_c;
  logic [CW-1:0] bits_c;
  logic [PW-1:0] prod;
  logic          mode_ok;
  logic          ok;

  assign mode_e = bmode_e'(mode);
  assign fs     = CW'(fs_ratio(fs_sel));

  always_comb begin
    div_c   = '0;
    bits_c  = '0;
    mode_ok = 1'b1;
    case (mode_e)
      MODE_POW2: begin
        mode_ok = (div_log2 <= MAX_LOG2);
        div_c   = CW'(1) << div_log2;
        bits_c  = fs >> div_log2;
      end
      MODE_RATE: begin
        bits_c = rate_x64 ? CW'(64) : CW'(32);
        div_c  = fs / bits_c;
      end
      MODE_RCW: begin
        bits_c = (CW'(chan_m1) + CW'(1)) * CW'(word_len(word_sel))
                 * (rcw_x2 ? CW'(2) : CW'(1));
        div_c  = fs / bits_c;
      end
      default: mode_ok = 1'b0;
    endcase
  end

  assign prod = PW'(div_c) * PW'(bits_c);
  assign ok   = mode_ok && (div_c != '0) && (prod == PW'(fs)) && !bits_c[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cand_div  <= '0;
      cand_bits <= '0;
      cand_err  <= 1'b0;
      cand_vld  <= 1'b0;
    end else begin
      cand_div  <= div_c;
      cand_bits <= bits_c;
      cand_err  <= !ok;
      cand_vld  <= 1'b1;
    end
  end

endmodule

// File: rtl/aclk_frame_timer.sv
// Bit-phase and bit-count counters; swaps configuration at frame ends and
// registers every output from next-state values.
module aclk_frame_timer #(
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cand_div,
  input  logic [CW-1:0] cand_bits,
  input  logic          cand_err,
  input  logic          cand_vld,
  output logic          bclk_q,
  output logic          lrclk_q,
  output logic          shift_q,
  output logic          sample_q,
  output logic          frame_q,
  output logic          err_q,
  output logic          pass_q
);

  logic          live, live_n;
  logic          err_n;
  logic [CW-1:0] a_div, a_bits, a_lo, a_half;
  logic [CW-1:0] div_n, bits_n, lo_n, half_n;
  logic [CW-1:0] ph, bc, ph_n, bc_n;
  logic          last_ph, frame_end, load;
  logic          bclk_n, lr_n, shift_n, sample_n, frame_n, pass_n;

  assign last_ph   = (ph == a_div - CW'(1));
  assign frame_end = last_ph && (bc == a_bits - CW'(1));
  assign load      = cand_vld && (!live || frame_end);

  always_comb begin
    live_n = live;
    err_n  = err_q;
    div_n  = a_div;
    bits_n = a_bits;
    lo_n   = a_lo;
    half_n = a_half;
    ph_n   = ph;
    bc_n   = bc;
    if (load) begin
      div_n  = cand_div;
      bits_n = cand_bits;
      lo_n   = (cand_div + CW'(1)) >> 1;
      half_n = cand_bits >> 1;
      err_n  = cand_err;
      live_n = !cand_err;
      ph_n   = '0;
      bc_n   = '0;
    end else if (live) begin
      ph_n = last_ph ? '0 : ph + CW'(1);
      bc_n = frame_end ? '0 : (last_ph ? bc + CW'(1) : bc);
    end
  end

  always_comb begin
    bclk_n   = 1'b0;
    lr_n     = 1'b0;
    shift_n  = 1'b0;
    sample_n = 1'b0;
    frame_n  = 1'b0;
    pass_n   = 1'b0;
    if (live_n) begin
      pass_n   = (div_n == CW'(1));
      bclk_n   = !pass_n && (ph_n >= lo_n);
      shift_n  = (ph_n == '0);
      sample_n = pass_n || (ph_n == lo_n);
      frame_n  = (ph_n == '0) && (bc_n == '0);
      lr_n     = (bc_n >= half_n);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live     <= 1'b0;
      err_q    <= 1'b0;
      a_div    <= '0;
      a_bits   <= '0;
      a_lo     <= '0;
      a_half   <= '0;
      ph       <= '0;
      bc       <= '0;
      bclk_q   <= 1'b0;
      lrclk_q  <= 1'b0;
      shift_q  <= 1'b0;
      sample_q <= 1'b0;
      frame_q  <= 1'b0;
      pass_q   <= 1'b0;
    end else begin
      live     <= live_n;
      err_q    <= err_n;
      a_div    <= div_n;
      a_bits   <= bits_n;
      a_lo     <= lo_n;
      a_half   <= half_n;
      ph       <= ph_n;
      bc       <= bc_n;
      bclk_q   <= bclk_n;
      lrclk_q  <= lr_n;
      shift_q  <= shift_n;
      sample_q <= sample_n;
      frame_q  <= frame_n;
      pass_q   <= pass_n;
    end
  end

endmodule

// File: rtl/aclk_gen.sv
module aclk_gen #(
  parameter int CW = 11
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] cfg_mode,
  input  logic [2:0] cfg_fs_sel,
  input  logic [2:0] cfg_div_log2,
  input  logic       cfg_rate_x64,
  input  logic [2:0] cfg_chan_m1,
  input  logic [1:0] cfg_word_sel,
  input  logic       cfg_rcw_x2,
  output logic       bclk,
  output logic       lrclk,
  output logic       shift_stb,
  output logic       sample_stb,
  output logic       frame_stb,
  output logic       cfg_err
);

  logic [CW-1:0] cand_div, cand_bits;
  logic          cand_err, cand_vld;
  logic          bclk_q, pass_q;

  aclk_cfg_calc #(.CW(CW)) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .mode      (cfg_mode),
    .fs_sel    (cfg_fs_sel),
    .div_log2  (cfg_div_log2),
    .rate_x64  (cfg_rate_x64),
    .chan_m1   (cfg_chan_m1),
    .word_sel  (cfg_word_sel),
    .rcw_x2    (cfg_rcw_x2),
    .cand_div  (cand_div),
    .cand_bits (cand_bits),
    .cand_err  (cand_err),
    .cand_vld  (cand_vld)
  );

  aclk_frame_timer #(.CW(CW)) u_tmr (
    .clk       (clk),
    .rst       (rst),
    .cand_div  (cand_div),
    .cand_bits (cand_bits),
    .cand_err  (cand_err),
    .cand_vld  (cand_vld),
    .bclk_q    (bclk_q),
    .lrclk_q   (lrclk),
    .shift_q   (shift_stb),
    .sample_q  (sample_stb),
    .frame_q   (frame_stb),
    .err_q     (cfg_err),
    .pass_q    (pass_q)
  );

  // divide-by-one: the master clock itself is the bit clock
  assign bclk = pass_q ? clk : bclk_q;

endmodule

// File: rtl/aclk_gen_chk.sv
module aclk_gen_chk (
  input logic clk,
  input logic rst,
  input logic bclk,
  input logic lrclk,
  input logic shift_stb,
  input logic sample_stb,
  input logic frame_stb,
  input logic cfg_err
);

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!bclk && !lrclk && !shift_stb && !sample_stb && !frame_stb && !cfg_err));

  assert_err_silent_R8: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> (!bclk && !lrclk && !shift_stb && !sample_stb && !frame_stb));

  assert_lr_on_fall_R7: assert property (@(posedge clk) disable iff (rst)
    (!cfg_err && (lrclk != $past(lrclk))) |-> shift_stb);

  assert_frame_start_R11: assert property (@(posedge clk) disable iff (rst)
    frame_stb |-> (shift_stb && !lrclk));

endmodule

bind aclk_gen aclk_gen_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .bclk       (bclk),
  .lrclk      (lrclk),
  .shift_stb  (shift_stb),
  .sample_stb (sample_stb),
  .frame_stb  (frame_stb),
  .cfg_err    (cfg_err)
);

// File: tb/aclk_gen_tb.sv
`timescale 1ns/1ps
module aclk_gen_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] cfg_mode = 2'd0;
  logic [2:0] cfg_fs_sel = 3'd2;
  logic [2:0] cfg_div_log2 = 3'd2;
  logic       cfg_rate_x64 = 1'b0;
  logic [2:0] cfg_chan_m1 = 3'd1;
  logic [1:0] cfg_word_sel = 2'd0;
  logic       cfg_rcw_x2 = 1'b0;
  logic       bclk, lrclk, shift_stb, sample_stb, frame_stb, cfg_err;

  always #2 clk = ~clk;

  aclk_gen u_dut (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_fs_sel(cfg_fs_sel),
    .cfg_div_log2(cfg_div_log2), .cfg_rate_x64(cfg_rate_x64),
    .cfg_chan_m1(cfg_chan_m1), .cfg_word_sel(cfg_word_sel),
    .cfg_rcw_x2(cfg_rcw_x2), .bclk(bclk), .lrclk(lrclk),
    .shift_stb(shift_stb), .sample_stb(sample_stb),
    .frame_stb(frame_stb), .cfg_err(cfg_err)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;
  int cyc     = 0;

  // model state
  int  m_d = 0, m_b = 0, m_pos = 0;
  bit  m_live = 0, m_err = 0, m_cvld = 0;
  int  c_d = 0, c_b = 0;
  bit  c_e = 0;

  function automatic int fs_of(input int sel);
    int tbl [8] = '{128, 192, 256, 272, 384, 512, 768, 1536};
    return tbl[sel];
  endfunction

  function automatic int word_of(input int sel);
    int tbl [4] = '{16, 20, 24, 32};
    return tbl[sel];
  endfunction

  // expected cycles per bit, bits per frame and error from R2..R5, R8
  task automatic calc(output int d, output int b, output bit e);
    int fs;
    fs = fs_of(int'(cfg_fs_sel));
    d = 0; b = 0; e = 0;
    case (int'(cfg_mode))
      0: begin
        if (cfg_div_log2 > 3'd4) e = 1;
        else begin
          d = 2 ** int'(cfg_div_log2);
          b = fs / d;
          if (fs % d != 0) e = 1;
        end
      end
      1: begin
        b = cfg_rate_x64 ? 64 : 32;
        d = fs / b;
        if (fs % b != 0) e = 1;
      end
      2: begin
        b = (int'(cfg_chan_m1) + 1) * word_of(int'(cfg_word_sel)) * (cfg_rcw_x2 ? 2 : 1);
        d = fs / b;
        if (fs % b != 0) e = 1;
      end
      default: e = 1;
    endcase
    if (d == 0 || (b % 2) != 0) e = 1;
  endtask

  task automatic model_step();
    if (rst) begin
      m_d = 0; m_b = 0; m_pos = 0; m_live = 0; m_err = 0; m_cvld = 0;
      return;
    end
    if (m_cvld && (!m_live || m_pos == m_d * m_b - 1)) begin
      m_d = c_d; m_b = c_b; m_err = c_e; m_live = !c_e; m_pos = 0;
    end else if (m_live) begin
      m_pos++;
    end
    calc(c_d, c_b, c_e);
    m_cvld = 1;
  endtask

  task automatic cmp(input string tag, input string what, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b at cycle %0d", tag, what, act, exp, cyc);
    end
  endtask

  task automatic check_all(input bit high_phase);
    int ph, bt, lo;
    logic eb, el, es, ea, ef;
    eb = 0; el = 0; es = 0; ea = 0; ef = 0;
    if (m_live) begin
      ph = m_pos % m_d; bt = m_pos / m_d; lo = (m_d + 1) / 2;
      eb = (m_d == 1) ? high_phase : (ph >= lo);
      es = (ph == 0);
      ea = (m_d == 1) || (ph == lo);
      ef = (m_pos == 0);
      el = (bt >= m_b / 2);
    end
    cmp((m_live && m_d == 1) ? "R10" : "R6", "bclk", bclk, eb);
    cmp((m_live && m_d == 1) ? "R10" : "R6", "shift_stb", shift_stb, es);
    cmp((m_live && m_d == 1) ? "R10" : "R6", "sample_stb", sample_stb, ea);
    cmp("R7", "lrclk", lrclk, el);
    cmp("R11", "frame_stb", frame_stb, ef);
    cmp("R8", "cfg_err", cfg_err, m_err);
  endtask

  // one clock: model the coming edge, then check both phases
  task automatic tick();
    model_step();
    @(posedge clk);
    #1;
    check_all(1'b1);
    @(negedge clk);
    check_all(1'b0);
  endtask

  task automatic count_check(input string tag, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic ticks_to_frame(output int n);
    n = 0;
    do begin tick(); n++; end while (!frame_stb && n < 5000);
  endtask

  // measures frame length and bit period of a running valid setting
  task automatic measure(input string tag, input int exp_frame, input int exp_bit);
    int n, k;
    ticks_to_frame(n);
    ticks_to_frame(n);
    count_check("R2", "frame length", n, exp_frame);
    k = 0;
    do begin tick(); k++; end while (!shift_stb && k < 200);
    count_check(tag, "bit period", k, exp_bit);
  endtask

  task automatic set_cfg(input int md, input int fs, input int k, input int x64,
                         input int ch, input int ws, input int x2);
    cfg_mode = 2'(md); cfg_fs_sel = 3'(fs); cfg_div_log2 = 3'(k);
    cfg_rate_x64 = 1'(x64); cfg_chan_m1 = 3'(ch); cfg_word_sel = 2'(ws); cfg_rcw_x2 = 1'(x2);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected<190000 cycles", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int n, p, f_old;
    void'($urandom(32'd20240611));
    @(negedge clk);
    // R1: reset state
    for (int i = 0; i < 3; i++) tick();
    rst = 1'b0;
    tick();  // first cycle after release: still quiet (R1)
    cmp("R1", "cfg_err after reset", cfg_err, 1'b0);
    cmp("R1", "frame_stb after reset", frame_stb, 1'b0);

    // R3: divide by 4 at FS 256
    set_cfg(0, 2, 2, 0, 0, 0, 0);
    measure("R3", 256, 4);
    // R3: divide by 16 at FS 192
    set_cfg(0, 1, 4, 0, 0, 0, 0);
    measure("R3", 192, 16);
    // R4: FS 192 with 64 bits per frame, odd period of 3
    set_cfg(1, 1, 0, 1, 0, 0, 0);
    measure("R4", 192, 3);
    // R4: FS 1536 with 32 bits per frame
    set_cfg(1, 7, 0, 0, 0, 0, 0);
    measure("R4", 1536, 48);
    // R5: stereo 16-bit x1 at FS 256 -> 32 bits, period 8
    set_cfg(2, 2, 0, 0, 1, 0, 0);
    measure("R5", 256, 8);
    // R5: stereo 24-bit x2 at FS 384 -> 96 bits, period 4
    set_cfg(2, 4, 0, 0, 1, 2, 1);
    measure("R5", 384, 4);
    // R10: divide by 1 at FS 128
    set_cfg(0, 0, 0, 0, 0, 0, 0);
    measure("R10", 128, 1);

    // R8: FS 272 with 32 bits per frame is not whole
    set_cfg(1, 3, 0, 0, 0, 0, 0);
    for (int i = 0; i < 300; i++) tick();
    cmp("R8", "cfg_err on 272/32", cfg_err, 1'b1);
    // R8: divide 16 at FS 272 leaves 17 bits (odd)
    set_cfg(0, 3, 4, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) tick();
    cmp("R8", "cfg_err on odd bit count", cfg_err, 1'b1);
    // R8: reserved mode, then recovery within two cycles
    set_cfg(3, 2, 0, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) tick();
    cmp("R8", "cfg_err on mode 3", cfg_err, 1'b1);
    set_cfg(0, 3, 3, 0, 0, 0, 0);
    tick(); tick();
    cmp("R8", "recovery cfg_err", cfg_err, 1'b0);
    cmp("R8", "recovery frame_stb", frame_stb, 1'b1);

    // R9: change mid-frame; old frame must finish, new one follows
    set_cfg(0, 2, 1, 0, 0, 0, 0);
    ticks_to_frame(n);
    for (int i = 0; i < 77; i++) tick();
    p = m_pos; f_old = 256;
    set_cfg(1, 5, 0, 1, 0, 0, 0);
    ticks_to_frame(n);
    count_check("R9", "cycles to boundary", n, f_old - p);
    ticks_to_frame(n);
    count_check("R9", "new frame length", n, 512);

    // random settings, each swapped in at an arbitrary point
    for (int r = 0; r < 30; r++) begin
      int md;
      md = ($urandom % 8 == 0) ? 3 : int'($urandom % 3);
      set_cfg(md, int'($urandom % 8), int'($urandom % 6), int'($urandom % 2),
              int'($urandom % 8), int'($urandom % 4), int'($urandom % 2));
      for (int i = 0; i < 1500 + int'($urandom % 700); i++) tick();
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule